// File: doc/BRIEF.md
# Hardware-Reduced Sleep State Controller

This block sequences a platform between the working state and a small set of sleeping states through two byte-wide I/O registers. Software requests sleep with one byte write to the sleep control register that carries a sleep type code and a go bit together. The block checks the code, runs a fixed handshake period with the platform, and then holds the platform asleep until a wake condition is seen.

A wake condition is any wake event whose software enable is set, or the power button, which cannot be masked. When a wake condition is seen, the block captures which inputs caused it into a wake source register. It then passes through a one-cycle waking state and returns to working. On that return it raises a wake status flag, which software polls and clears by writing one. A wake that arrives during the entry handshake cancels the entry and takes the same waking path. Soft-off uses the same wake qualification as the other sleeping types, so an enabled remote wake can still start the platform.

Top module: `hr_sleep_ctrl`

## Requirements
- R1: A write to the control address (default 0x405) with bit 5 set and bits [4:2] equal to 5, 6 or 7 moves the block from working to entering. From the next cycle `plat_sleep_req_o` is 1 and `plat_sleep_type_o` holds the written code.
- R2: A control write with bit 5 clear, or with bits [4:2] equal to 0 to 4, is ignored. The block stays in working, and the type readback keeps its previous value.
- R3: Entering lasts exactly ENTRY_CYCLES cycles (default 4), with `pwr_state_o`=1. After that `pwr_state_o`=2 and `plat_asleep_o`=1. State encoding: 0 working, 1 entering, 2 sleeping, 3 waking.
- R4: While entering or sleeping, a wake event whose matching `wake_en_i` bit is 0 has no effect.
- R5: The power button wakes the block from entering or sleeping, whatever the wake enables are.
- R6: With type 7 (soft-off), an enabled wake event wakes the block in the same way as with types 5 and 6.
- R7: A wake condition seen during entering aborts the entry, and the next state is waking.
- R8: Waking lasts one cycle and is followed by working. At that same edge the wake status flag becomes 1, and it reads as bit 7 of the status address (default 0x401), with all other bits 0.
- R9: Writing a status byte with bit 7 set clears the flag, and writing with bit 7 clear leaves it unchanged. A clear written while the block is in waking loses to the set, so the flag reads 1. An accepted sleep request also clears the flag.
- R10: At the wake edge, the wake source register (default 0x402) captures the enabled active events in bits [NUM_WAKE-1:0] and the power button in bit NUM_WAKE. It holds that value in working and is cleared by the next accepted sleep request.
- R11: A control readback gives the latched type in bits [4:2]. All other bits, including bit 5, read 0. Reads of any other address return 0.
- R12: A control write while the block is not in working is ignored, and the latched type does not change.
- R13: After reset the block is in working, both platform outputs are 0, and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | ADDR_W | I/O address for reads and writes |
| io_wr_i | input | 1 | Byte write strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for io_addr_i (combinational) |
| wake_evt_i | input | NUM_WAKE | Wake event levels |
| wake_en_i | input | NUM_WAKE | Software wake enables, one per event |
| pwr_btn_i | input | 1 | Power button, cannot be masked |
| plat_sleep_req_o | output | 1 | Sleep requested from the platform (entering or sleeping) |
| plat_sleep_type_o | output | 3 | Latched sleep type code |
| plat_asleep_o | output | 1 | Platform held in the sleeping state |
| pwr_state_o | output | 2 | Sequencer state |

## Verification
The two functions that can meet in one cycle are the return from waking, which sets the wake status flag, and a software write of one to that flag, which clears it. The bench provokes this by pulsing a wake event and then issuing the clearing write at the very next edge, while the sequencer is in waking. A flag reading 1 afterwards is the correct result. A second collision puts an enabled wake in the middle of the entry handshake, and the result is judged by an immediate move to waking with the source captured. A behavioural model predicts state, outputs and readback for every cycle.

// File: rtl/hr_sleep_pkg.sv
package hr_sleep_pkg;
  typedef enum logic [1:0] {
    ST_WORK  = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  localparam int TYPE_LSB = 2;
  localparam int TYPE_MSB = 4;
  localparam int GO_BIT   = 5;
  localparam int WAK_BIT  = 7;

  function automatic logic type_ok(input logic [2:0] t);
    return (t == 3'd5) || (t == 3'd6) || (t == 3'd7);
  endfunction
endpackage

// File: rtl/hr_sleep_regs.sv
module hr_sleep_regs
  import hr_sleep_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0405,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 16'h0401,
  parameter logic [ADDR_W-1:0] SRC_ADDR  = 16'h0402,
  parameter int                SRC_W     = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [2:0]        typ_i,
  input  logic              wak_sts_i,
  input  logic [SRC_W-1:0]  src_i,
  output logic              go_o,
  output logic [2:0]        go_type_o,
  output logic              sts_clr_o,
  output logic [7:0]        rdata_o
);
  localparam int RD_W = (SRC_W < 8) ? SRC_W : 8;

  logic       sel_ctrl, sel_sts, sel_src;
  logic [7:0] src_byte;
  logic       unused_wdata;

  assign sel_ctrl = (addr_i == CTRL_ADDR);
  assign sel_sts  = (addr_i == STS_ADDR);
  assign sel_src  = (addr_i == SRC_ADDR);

  assign go_type_o = wdata_i[TYPE_MSB:TYPE_LSB];
  assign go_o      = wr_i && sel_ctrl && wdata_i[GO_BIT] && type_ok(go_type_o);
  assign sts_clr_o = wr_i && sel_sts && wdata_i[WAK_BIT];

  assign unused_wdata = ^{wdata_i[6], wdata_i[1:0]};

  always_comb begin
    src_byte = '0;
    for (int i = 0; i < RD_W; i++) src_byte[i] = src_i[i];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)     rdata_o[TYPE_MSB:TYPE_LSB] = typ_i;
    else if (sel_sts) rdata_o[WAK_BIT] = wak_sts_i;
    else if (sel_src) rdata_o = src_byte;
  end
endmodule

// File: rtl/hr_sleep_seq.sv
module hr_sleep_seq
  import hr_sleep_pkg::*;
#(
  parameter int ENTRY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [2:0] go_type_i,
  input  logic       wake_hit_i,
  output pwr_state_e state_o,
  output logic [2:0] typ_o,
  output logic       accept_o,
  output logic       capture_o,
  output logic       wake_done_o
);
  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       typ_q;

  assign accept_o    = (state_q == ST_WORK) && go_i;
  assign capture_o   = ((state_q == ST_ENTER) || (state_q == ST_SLEEP)) && wake_hit_i;
  assign wake_done_o = (state_q == ST_WAKE);
  assign state_o     = state_q;
  assign typ_o       = typ_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_WORK: if (go_i) begin
        state_d = ST_ENTER;
        cnt_d   = '0;
      end
      ST_ENTER: begin
        if (wake_hit_i)            state_d = ST_WAKE;  // abort
        else if (cnt_q == CNT_LAST) state_d = ST_SLEEP;
        else                        cnt_d = cnt_q + 1'b1;
      end
      ST_SLEEP: if (wake_hit_i) state_d = ST_WAKE;
      ST_WAKE:  state_d = ST_WORK;
      default:  state_d = ST_WORK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WORK;
      cnt_q   <= '0;
      typ_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept_o) typ_q <= go_type_i;
    end
  end
endmodule

// File: rtl/hr_sleep_wake.sv
module hr_sleep_wake #(
  parameter int NUM_WAKE = 7,
  parameter int SRC_W    = NUM_WAKE + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAKE-1:0] evt_i,
  input  logic [NUM_WAKE-1:0] en_i,
  input  logic                btn_i,
  input  logic                accept_i,
  input  logic                capture_i,
  input  logic                wake_done_i,
  input  logic                sts_clr_i,
  output logic                hit_o,
  output logic [SRC_W-1:0]    src_o,
  output logic                wak_sts_o
);
  logic [NUM_WAKE-1:0] qual;
  logic [SRC_W-1:0]    src_q;
  logic                sts_q;

  assign qual      = evt_i & en_i;
  assign hit_o     = btn_i || (|qual);
  assign src_o     = src_q;
  assign wak_sts_o = sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (accept_i)       src_q <= '0;
      else if (capture_i) src_q <= {btn_i, qual};
      // set on return to working beats a concurrent software clear
      if (wake_done_i)                sts_q <= 1'b1;
      else if (accept_i || sts_clr_i) sts_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hr_sleep_ctrl.sv
module hr_sleep_ctrl
  import hr_sleep_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR    = 16'h0405,
  parameter logic [ADDR_W-1:0] STS_ADDR     = 16'h0401,
  parameter logic [ADDR_W-1:0] SRC_ADDR     = 16'h0402,
  parameter int                NUM_WAKE     = 7,
  parameter int                ENTRY_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   io_addr_i,
  input  logic                io_wr_i,
  input  logic [7:0]          io_wdata_i,
  output logic [7:0]          io_rdata_o,
  input  logic [NUM_WAKE-1:0] wake_evt_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  input  logic                pwr_btn_i,
  output logic                plat_sleep_req_o,
  output logic [2:0]          plat_sleep_type_o,
  output logic                plat_asleep_o,
  output logic [1:0]          pwr_state_o
);
  localparam int SRC_W = NUM_WAKE + 1;

  pwr_state_e       state;
  logic             go, sts_clr, accept, capture, wake_done, wake_hit, wak_sts;
  logic [2:0]       go_type, typ;
  logic [SRC_W-1:0] wake_src;

  hr_sleep_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STS_ADDR(STS_ADDR),
    .SRC_ADDR(SRC_ADDR), .SRC_W(SRC_W)
  ) u_regs (
    .addr_i(io_addr_i), .wr_i(io_wr_i), .wdata_i(io_wdata_i),
    .typ_i(typ), .wak_sts_i(wak_sts), .src_i(wake_src),
    .go_o(go), .go_type_o(go_type), .sts_clr_o(sts_clr), .rdata_o(io_rdata_o)
  );

  hr_sleep_seq #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .go_type_i(go_type),
    .wake_hit_i(wake_hit), .state_o(state), .typ_o(typ),
    .accept_o(accept), .capture_o(capture), .wake_done_o(wake_done)
  );

  hr_sleep_wake #(.NUM_WAKE(NUM_WAKE), .SRC_W(SRC_W)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(wake_evt_i), .en_i(wake_en_i),
    .btn_i(pwr_btn_i), .accept_i(accept), .capture_i(capture),
    .wake_done_i(wake_done), .sts_clr_i(sts_clr),
    .hit_o(wake_hit), .src_o(wake_src), .wak_sts_o(wak_sts)
  );

  assign plat_sleep_req_o  = (state == ST_ENTER) || (state == ST_SLEEP);
  assign plat_asleep_o     = (state == ST_SLEEP);
  assign plat_sleep_type_o = typ;
  assign pwr_state_o       = state;
endmodule

// File: rtl/hr_sleep_ctrl_chk.sv
module hr_sleep_ctrl_chk #(
  parameter int ENTRY_CYCLES = 4,
  parameter int SRC_W        = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             plat_sleep_req_o,
  input logic             plat_asleep_o,
  input logic [2:0]       plat_sleep_type_o,
  input logic             pwr_btn_i,
  input logic             wak_sts,
  input logic             accept,
  input logic [SRC_W-1:0] wake_src
);
  int unsigned enter_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                enter_cnt <= 0;
    else if (!plat_sleep_req_o)                 enter_cnt <= 0;
    else if (!plat_asleep_o)                    enter_cnt <= enter_cnt + 1;
  end

  assert_entry_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(plat_asleep_o) |-> (enter_cnt == ENTRY_CYCLES));

  assert_type_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plat_sleep_type_o == 3'd0) || (plat_sleep_type_o >= 3'd5));

  assert_type_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plat_sleep_req_o |=> $stable(plat_sleep_type_o));

  assert_button_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plat_sleep_req_o && pwr_btn_i) |=> !plat_sleep_req_o);

  assert_sts_after_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(plat_sleep_req_o) |=> wak_sts);

  assert_src_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!plat_sleep_req_o && !accept) |=> $stable(wake_src));
endmodule

bind hr_sleep_ctrl hr_sleep_ctrl_chk #(.ENTRY_CYCLES(ENTRY_CYCLES), .SRC_W(SRC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .plat_sleep_req_o(plat_sleep_req_o),
  .plat_asleep_o(plat_asleep_o), .plat_sleep_type_o(plat_sleep_type_o),
  .pwr_btn_i(pwr_btn_i), .wak_sts(wak_sts), .accept(accept), .wake_src(wake_src)
);

// File: tb/hr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module hr_sleep_ctrl_tb;
  localparam int NW = 7;
  localparam logic [15:0] A_CTRL = 16'h0405;
  localparam logic [15:0] A_STS  = 16'h0401;
  localparam logic [15:0] A_SRC  = 16'h0402;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   addr = '0;
  logic          wr = 1'b0;
  logic [7:0]    wd = '0;
  logic [7:0]    rd;
  logic [NW-1:0] evt = '0, en = '0;
  logic          btn = 1'b0;
  logic          req, asleep;
  logic [2:0]    typ;
  logic [1:0]    st;

  int    errs = 0, checks = 0;
  bit    done = 0;
  string tag = "R13";

  // reference model
  int         m_st = 0, m_cnt = 0;
  logic [2:0] m_typ = '0;
  logic       m_sts = 1'b0;
  logic [7:0] m_src = '0;

  always #4 clk = ~clk;

  hr_sleep_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_wdata_i(wd),
    .io_rdata_o(rd), .wake_evt_i(evt), .wake_en_i(en), .pwr_btn_i(btn),
    .plat_sleep_req_o(req), .plat_sleep_type_o(typ), .plat_asleep_o(asleep),
    .pwr_state_o(st)
  );

  function automatic logic [7:0] m_rd(input logic [15:0] a);
    if (a == A_CTRL) return {3'b000, m_typ, 2'b00};
    if (a == A_STS)  return {m_sts, 7'b0};
    if (a == A_SRC)  return m_src;
    return 8'h00;
  endfunction

  task automatic chk(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_typ = '0; m_sts = 0; m_src = '0;
    end else begin
      logic hit, go, clr;
      hit = btn || ((evt & en) != '0);
      go  = wr && addr == A_CTRL && wd[5] && wd[4:2] >= 3'd5;
      clr = wr && addr == A_STS && wd[7];
      case (m_st)
        0: if (go) begin
             m_st = 1; m_cnt = 0; m_typ = wd[4:2]; m_sts = 0; m_src = '0;
           end else if (clr) m_sts = 0;
        1: begin
             if (hit) begin m_st = 3; m_src = {btn, evt & en}; end
             else if (m_cnt == 3) m_st = 2;
             else m_cnt++;
             if (clr) m_sts = 0;
           end
        2: begin
             if (hit) begin m_st = 3; m_src = {btn, evt & en}; end
             if (clr) m_sts = 0;
           end
        default: begin m_st = 0; m_sts = 1; end
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({tag, " state"}, st, m_st);
      chk({tag, " req"}, req, (m_st == 1 || m_st == 2));
      chk({tag, " asleep"}, asleep, m_st == 2);
      chk({tag, " type"}, typ, m_typ);
      chk({tag, " rdata"}, rd, m_rd(addr));
    end
  end

  // all tasks start right after a negedge
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wd = '0;
  endtask

  task automatic pulse(input logic [NW-1:0] e, input logic b);
    evt = e; btn = b;
    @(negedge clk);
    evt = '0; btn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string t, input logic [15:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(t, rd, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R13";
    rd_chk("R13 ctrl", A_CTRL, 8'h00);
    rd_chk("R13 sts", A_STS, 8'h00);
    rd_chk("R13 src", A_SRC, 8'h00);
    chk("R13 state", st, 0);

    tag = "R2";
    io_write(A_CTRL, 8'h14);  // type 5, no go bit
    io_write(A_CTRL, 8'h20);  // type 0
    io_write(A_CTRL, 8'h2C);  // type 3
    io_write(A_CTRL, 8'h30);  // type 4
    io_write(16'h0404, 8'h34);  // wrong address
    idle(1);
    chk("R2 still working", st, 0);
    rd_chk("R2 type kept", A_CTRL, 8'h00);

    tag = "R1";
    io_write(A_CTRL, 8'h34);
    chk("R1 req", req, 1);
    chk("R1 type", typ, 5);
    rd_chk("R11 readback", A_CTRL, 8'h14);
    tag = "R3";
    idle(3);
    chk("R3 still entering", st, 1);
    idle(1);
    chk("R3 asleep", asleep, 1);
    tag = "R12";
    io_write(A_CTRL, 8'h3C);
    chk("R12 type kept", typ, 5);

    tag = "R4";
    en = 7'h01;
    pulse(7'h02, 1'b0);
    idle(2);
    chk("R4 disabled ignored", st, 2);
    pulse(7'h03, 1'b0);
    tag = "R8";
    chk("R8 waking", st, 3);
    idle(1);
    chk("R8 working", st, 0);
    rd_chk("R8 sts", A_STS, 8'h80);
    rd_chk("R10 src", A_SRC, 8'h01);
    idle(3);
    rd_chk("R10 src held", A_SRC, 8'h01);

    tag = "R9";
    io_write(A_STS, 8'h7F);
    rd_chk("R9 zero write", A_STS, 8'h80);
    io_write(A_STS, 8'h80);
    rd_chk("R9 cleared", A_STS, 8'h00);

    tag = "R5";
    en = '0;
    io_write(A_CTRL, 8'h38);
    idle(6);
    pulse(7'h7F, 1'b1);
    idle(1);
    chk("R5 button wake", st, 0);
    rd_chk("R5 src", A_SRC, 8'h80);
    chk("R6 type6", typ, 6);

    tag = "R6";
    en = 7'h7F;
    io_write(A_CTRL, 8'h3C);
    rd_chk("R10 src cleared", A_SRC, 8'h00);
    rd_chk("R9 sts cleared by entry", A_STS, 8'h00);
    idle(6);
    chk("R6 soft-off asleep", asleep, 1);
    pulse(7'h40, 1'b0);
    idle(1);
    chk("R6 woke", st, 0);
    rd_chk("R6 src", A_SRC, 8'h40);

    tag = "R7";
    io_write(A_CTRL, 8'h34);
    idle(2);
    pulse(7'h08, 1'b0);
    chk("R7 abort to waking", st, 3);
    idle(1);
    rd_chk("R7 src", A_SRC, 8'h08);
    rd_chk("R7 sts", A_STS, 8'h80);

    tag = "R9";
    io_write(A_CTRL, 8'h38);
    idle(6);
    pulse(7'h10, 1'b0);
    io_write(A_STS, 8'h80);  // lands in waking: set wins
    rd_chk("R9 set wins", A_STS, 8'h80);
    io_write(A_STS, 8'h80);
    rd_chk("R9 later clear", A_STS, 8'h00);

    tag = "R11";
    rd_chk("R11 other addr", 16'h0400, 8'h00);
    rd_chk("R11 ctrl", A_CTRL, 8'h18);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule